// File: doc/BRIEF.md
# I2C Interrupt Request Flag Logic

This block owns the single interrupt-request flag of an I2C controller. It takes single-cycle event strobes from the bus-state and shift logic (start seen, stop seen, SCL rising and falling edges, own-address match, general-call match, arbitration lost, and the sampled acknowledge bit), and the control bits that select master or slave operation, wait insertion, acknowledge checking, the arbitration-lost interrupt enable and the stop-interrupt mask. From these it decides the clock cycle in which the flag must rise. Software clears the flag by reading it as 1 and then writing 0.

An internal SCL edge counter numbers the clocks of each byte and produces two strobes: the falling edge of the 8th clock, where a wait is inserted before the acknowledge, and the rising edge of the 9th clock, where a transfer ends. A small session tracker remembers whether the current transfer was addressed to this controller, was a general call, or follows a loss of arbitration. These sessions decide which 9th-clock edges raise the flag. The interrupt line to the CPU is the flag gated by a global interrupt enable.

Every strobe is sampled on the system clock, and the flag and acknowledge status change on the following clock edge.

Top module: `i2c_irq_flag`

## Requirements
- R1: After reset the flag, the interrupt output and the received-acknowledge status are all 0.
- R2: In master mode the flag is set by a detected start only if this controller requested a start (issue_start strobe) beforehand and no start has been detected since. A detected start without such a request leaves the flag at 0.
- R3: In master mode with wait enabled, the falling edge of the 8th SCL clock of a byte sets the flag. With wait disabled, that edge leaves the flag at 0.
- R4: In master mode the rising edge of the 9th SCL clock of every byte sets the flag.
- R5: On every 9th-clock rising edge the received-acknowledge status takes the sampled acknowledge bit. If acknowledge checking is enabled and that bit is 1, the flag is set in either mode.
- R6: An arbitration-lost strobe sets the flag only when the arbitration-lost interrupt enable is 1.
- R7: After arbitration has been lost, and until a stop is detected, an own-address match or a general-call match sets the flag.
- R8: In slave mode, after an own-address match, every 9th-clock rising edge sets the flag until the next start or stop is detected.
- R9: In slave mode, after a general-call match (address 0, write), every 9th-clock rising edge sets the flag until the next start or stop is detected.
- R10: A detected stop sets the flag when the stop mask is 0, and leaves it at 0 when the mask is 1.
- R11: A write of 0 clears the flag only if a read returned the flag as 1 since the last write. A write of 1 has no effect. A set event in the same cycle as a clearing write wins.
- R12: The interrupt output is 1 exactly when the flag is 1 and the global interrupt enable is 1.
- R13: The SCL counter counts rising edges 1 to 9 within each byte, wraps to 1 on the next byte, and returns to 0 on any start or stop. The 8th-fall and 9th-rise strobes are therefore timed from the most recent start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| wait_en | input | 1 | Insert a wait (and request) at the 8th SCL fall |
| ack_chk_en | input | 1 | Request on a received acknowledge of 1 |
| al_ie | input | 1 | Arbitration-lost interrupt enable |
| stop_mask | input | 1 | 1 masks the stop-detected request |
| gie | input | 1 | Global interrupt enable for the output |
| issue_start | input | 1 | Strobe: this controller requested a start |
| start_det | input | 1 | Strobe: start or repeated start seen on the bus |
| stop_det | input | 1 | Strobe: stop seen on the bus |
| scl_rise | input | 1 | Strobe: SCL rising edge |
| scl_fall | input | 1 | Strobe: SCL falling edge |
| ack_rx | input | 1 | Sampled SDA value, valid with the 9th rise |
| addr_match | input | 1 | Strobe: own slave address matched |
| gcall_match | input | 1 | Strobe: general-call address with write seen |
| arb_lost | input | 1 | Strobe: bus mastership lost |
| flag_rd | input | 1 | CPU read strobe of the flag |
| flag_wr | input | 1 | CPU write strobe of the flag |
| flag_wdata | input | 1 | Value written by the CPU |
| flag_q | output | 1 | Interrupt request flag |
| ack_status | output | 1 | Last received acknowledge bit |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
The bench walks bytes edge by edge, because a counter that is off by one edge would raise the flag on the 8th rise or the 9th fall instead of the 8th fall or the 9th rise. It checks that sessions end: a design that keeps the address or general-call session past a stop or a repeated start keeps raising requests on later bytes that belong to other devices. It covers the clearing protocol: a blind write of 0, a write of 1, and a clear that meets a set in the same cycle, where a wrong priority would lose an interrupt. It also checks the masked paths (stop mask, arbitration enable, wait disabled, a start this controller did not request), which a design that ignores the gate would turn into spurious requests.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  // Positions of the set sources in the request vector
  localparam int SRC_MSTART = 0;
  localparam int SRC_WAIT   = 1;
  localparam int SRC_MXFER  = 2;
  localparam int SRC_NACK   = 3;
  localparam int SRC_ALOST  = 4;
  localparam int SRC_ALADDR = 5;
  localparam int SRC_SADDR  = 6;
  localparam int SRC_SGCALL = 7;
  localparam int SRC_STOP   = 8;
  localparam int NSRC       = 9;

  typedef struct packed {
    logic master;
    logic wait_en;
    logic ack_chk;
    logic al_ie;
    logic stop_mask;
  } irq_ctrl_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic data_fall;
    logic ack_rise;
    logic ack_bit;
    logic addr;
    logic gcall;
    logic alost;
  } irq_evt_t;

  typedef struct packed {
    logic start_pend;
    logic addr_sess;
    logic gc_sess;
    logic al_sess;
  } irq_sess_t;

  // Next value of the per-byte SCL rising-edge count
  function automatic int unsigned next_edge(input int unsigned cnt, input int unsigned last);
    return (cnt >= last) ? 1 : cnt + 1;
  endfunction

  // Next value of the flag given set and clear requests
  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/i2c_irq_bitcnt.sv
module i2c_irq_bitcnt #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic scl_rise,
  input  logic scl_fall,
  output logic data_fall,
  output logic ack_rise
);
  import i2c_irq_pkg::*;

  localparam int LAST  = BITS + 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_cnt <= '0;
    end else if (restart) begin
      edge_cnt <= '0;
    end else if (scl_rise) begin
      edge_cnt <= CNT_W'(next_edge(int'(edge_cnt), LAST));
    end
  end

  // The count equals BITS while the last data clock is high
  assign data_fall = scl_fall && (int'(edge_cnt) == BITS) && !restart;
  assign ack_rise  = scl_rise && (int'(edge_cnt) == BITS) && !restart;

  p_cnt_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    int'(edge_cnt) <= LAST);

  p_cnt_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> edge_cnt == '0);

  p_cnt_wrap_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !restart && int'(edge_cnt) == LAST) |=> int'(edge_cnt) == 1);

endmodule

// File: rtl/i2c_irq_session.sv
module i2c_irq_session (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_start,
  input  i2c_irq_pkg::irq_evt_t  evt,
  output i2c_irq_pkg::irq_sess_t sess
);
  import i2c_irq_pkg::*;

  irq_sess_t sess_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sess_q <= '0;
    end else begin
      // Own start request waits for the bus to show the start
      if (issue_start)    sess_q.start_pend <= 1'b1;
      else if (evt.start) sess_q.start_pend <= 1'b0;

      // Transfer sessions end on any start or stop; a match opens one
      if (evt.addr)                   sess_q.addr_sess <= 1'b1;
      else if (evt.start || evt.stop) sess_q.addr_sess <= 1'b0;

      if (evt.gcall)                  sess_q.gc_sess <= 1'b1;
      else if (evt.start || evt.stop) sess_q.gc_sess <= 1'b0;

      // Lost-arbitration state lasts until the bus is released
      if (evt.alost)     sess_q.al_sess <= 1'b1;
      else if (evt.stop) sess_q.al_sess <= 1'b0;
    end
  end

  assign sess = sess_q;

  p_sess_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.stop && !evt.addr) |=> !sess_q.addr_sess);

  p_gc_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.start && !evt.gcall) |=> !sess_q.gc_sess);

  p_al_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_q.al_sess && !evt.stop) |=> sess_q.al_sess);

endmodule

// File: rtl/i2c_irq_setlogic.sv
module i2c_irq_setlogic (
  input  i2c_irq_pkg::irq_ctrl_t      ctrl,
  input  i2c_irq_pkg::irq_evt_t       evt,
  input  i2c_irq_pkg::irq_sess_t      sess,
  output logic [i2c_irq_pkg::NSRC-1:0] src
);
  import i2c_irq_pkg::*;

  always_comb begin
    src = '0;
    src[SRC_MSTART] = ctrl.master && evt.start && sess.start_pend;
    src[SRC_WAIT]   = ctrl.master && ctrl.wait_en && evt.data_fall;
    src[SRC_MXFER]  = ctrl.master && evt.ack_rise;
    src[SRC_NACK]   = ctrl.ack_chk && evt.ack_rise && evt.ack_bit;
    src[SRC_ALOST]  = ctrl.al_ie && evt.alost;
    src[SRC_ALADDR] = sess.al_sess && (evt.addr || evt.gcall);
    src[SRC_SADDR]  = !ctrl.master && sess.addr_sess && evt.ack_rise;
    src[SRC_SGCALL] = !ctrl.master && sess.gc_sess && evt.ack_rise;
    src[SRC_STOP]   = !ctrl.stop_mask && evt.stop;
  end

endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag #(
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic wait_en,
  input  logic ack_chk_en,
  input  logic al_ie,
  input  logic stop_mask,
  input  logic gie,
  input  logic issue_start,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic ack_rx,
  input  logic addr_match,
  input  logic gcall_match,
  input  logic arb_lost,
  input  logic flag_rd,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q,
  output logic ack_status,
  output logic irq
);
  import i2c_irq_pkg::*;

  irq_ctrl_t        ctrl;
  irq_evt_t         evt;
  irq_sess_t        sess;
  logic [NSRC-1:0]  set_src;
  logic             set_req;
  logic             clr_req;
  logic             rd_armed;
  logic             data_fall;
  logic             ack_rise;
  logic             flag_r;
  logic             ackst_r;

  assign ctrl = '{master: master_mode, wait_en: wait_en, ack_chk: ack_chk_en,
                  al_ie: al_ie, stop_mask: stop_mask};

  i2c_irq_bitcnt #(.BITS(BITS)) u_bitcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_det || stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .data_fall (data_fall),
    .ack_rise  (ack_rise)
  );

  assign evt = '{start: start_det, stop: stop_det, data_fall: data_fall,
                 ack_rise: ack_rise, ack_bit: ack_rx, addr: addr_match,
                 gcall: gcall_match, alost: arb_lost};

  i2c_irq_session u_session (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_start (issue_start),
    .evt         (evt),
    .sess        (sess)
  );

  i2c_irq_setlogic u_setlogic (
    .ctrl (ctrl),
    .evt  (evt),
    .sess (sess),
    .src  (set_src)
  );

  assign set_req = |set_src;
  assign clr_req = flag_wr && !flag_wdata && rd_armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_r   <= 1'b0;
      rd_armed <= 1'b0;
      ackst_r  <= 1'b0;
    end else begin
      flag_r <= next_flag(flag_r, set_req, clr_req);
      if (flag_wr)                rd_armed <= 1'b0;
      else if (flag_rd && flag_r) rd_armed <= 1'b1;
      if (ack_rise) ackst_r <= ack_rx;
    end
  end

  assign flag_q     = flag_r;
  assign ack_status = ackst_r;
  assign irq        = flag_r && gie;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!flag_q && !ack_status));

  p_mxfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ack_rise) |=> flag_q);

  p_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_chk_en && ack_rise && ack_rx) |=> (flag_q && ack_status));

  p_alost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (al_ie && arb_lost) |=> flag_q);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !stop_mask) |=> flag_q);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> !flag_q);

  p_wr_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wdata && flag_q) |=> flag_q);

  p_blind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !rd_armed && !flag_rd) |=> flag_q);

  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);

endmodule

// File: tb/test_i2c_irq_flag.sv
`timescale 1ns/1ps
module test_i2c_irq_flag;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b0, wait_en = 1'b0, ack_chk_en = 1'b0, al_ie = 1'b0;
  logic stop_mask = 1'b0, gie = 1'b0;
  logic issue_start = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic scl_rise = 1'b0, scl_fall = 1'b0, ack_rx = 1'b0;
  logic addr_match = 1'b0, gcall_match = 1'b0, arb_lost = 1'b0;
  logic flag_rd = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic flag_q, ack_status, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  i2c_irq_flag i_i2c_irq_flag (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .wait_en(wait_en),
    .ack_chk_en(ack_chk_en), .al_ie(al_ie), .stop_mask(stop_mask), .gie(gie),
    .issue_start(issue_start), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .ack_rx(ack_rx),
    .addr_match(addr_match), .gcall_match(gcall_match), .arb_lost(arb_lost),
    .flag_rd(flag_rd), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .flag_q(flag_q), .ack_status(ack_status), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Each strobe lasts one clock; the registered result is visible on return
  task automatic p_start;   start_det = 1;   @(negedge clk); start_det = 0;   endtask
  task automatic p_stop;    stop_det = 1;    @(negedge clk); stop_det = 0;    endtask
  task automatic p_issue;   issue_start = 1; @(negedge clk); issue_start = 0; endtask
  task automatic p_rise;    scl_rise = 1;    @(negedge clk); scl_rise = 0;    endtask
  task automatic p_fall;    scl_fall = 1;    @(negedge clk); scl_fall = 0;    endtask
  task automatic p_addr;    addr_match = 1;  @(negedge clk); addr_match = 0;  endtask
  task automatic p_gcall;   gcall_match = 1; @(negedge clk); gcall_match = 0; endtask
  task automatic p_alost;   arb_lost = 1;    @(negedge clk); arb_lost = 0;    endtask

  task automatic pairs(input int n);
    for (int i = 0; i < n; i++) begin p_rise(); p_fall(); end
  endtask

  task automatic do_read;  flag_rd = 1; @(negedge clk); flag_rd = 0; endtask
  task automatic do_write(input logic v);
    flag_wr = 1; flag_wdata = v; @(negedge clk); flag_wr = 0; flag_wdata = 0;
  endtask
  task automatic clear_flag; do_read(); do_write(1'b0); endtask

  task automatic t_reset;
    chk("R1 flag after reset", flag_q, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 ack_status after reset", ack_status, 1'b0);
  endtask

  task automatic t_master_wait;
    master_mode = 1; wait_en = 1;
    p_issue(); chk("R2 issued start pending, no flag yet", flag_q, 1'b0);
    p_start(); chk("R2 own start detected", flag_q, 1'b1);
    clear_flag(); chk("R11 clear after read", flag_q, 1'b0);
    pairs(7); p_rise(); chk("R3 no set before 8th fall", flag_q, 1'b0);
    p_fall(); chk("R3 8th fall with wait", flag_q, 1'b1);
    clear_flag();
    p_rise(); chk("R4 9th rise in master", flag_q, 1'b1);
    chk("R5 ack_status loads 0", ack_status, 1'b0);
    clear_flag();
    p_fall();
    pairs(1); chk("R13 wrap: 1st rise of next byte no set", flag_q, 1'b0);
  endtask

  task automatic t_master_nowait;
    master_mode = 1; wait_en = 0;
    p_start(); chk("R2 unrequested start no set", flag_q, 1'b0);
    pairs(8); chk("R3 8th fall without wait no set", flag_q, 1'b0);
    p_rise(); chk("R4 9th rise without wait", flag_q, 1'b1);
    clear_flag(); p_fall();
    // restart mid byte: count must begin again
    pairs(5); p_start(); pairs(8);
    chk("R13 restart realigns count", flag_q, 1'b0);
    p_rise(); chk("R13 9th rise after restart", flag_q, 1'b1);
    clear_flag(); p_fall();
    p_stop(); clear_flag();
  endtask

  task automatic t_ack;
    master_mode = 0; ack_chk_en = 1; ack_rx = 1;
    p_start(); chk("R5 slave start no set", flag_q, 1'b0);
    pairs(8); p_rise();
    chk("R5 nack with check sets flag", flag_q, 1'b1);
    chk("R5 ack_status is 1", ack_status, 1'b1);
    clear_flag(); p_fall();
    ack_chk_en = 0;
    pairs(8); p_rise();
    chk("R5 nack without check no set", flag_q, 1'b0);
    chk("R5 ack_status still 1", ack_status, 1'b1);
    p_fall(); ack_rx = 0;
    pairs(8); p_rise();
    chk("R5 ack_status loads 0", ack_status, 1'b0);
    p_fall(); p_stop(); clear_flag();
  endtask

  task automatic t_arb;
    master_mode = 1; al_ie = 1; stop_mask = 1;
    p_alost(); chk("R6 lost with enable", flag_q, 1'b1);
    clear_flag();
    al_ie = 0;
    p_alost(); chk("R6 lost without enable", flag_q, 1'b0);
    master_mode = 0;
    p_addr(); chk("R7 address after lost", flag_q, 1'b1);
    clear_flag();
    p_gcall(); chk("R7 general call after lost", flag_q, 1'b1);
    clear_flag();
    p_stop(); chk("R10 masked stop no set", flag_q, 1'b0);
    p_gcall(); chk("R7 lost state ended by stop", flag_q, 1'b0);
    p_stop(); stop_mask = 0;
  endtask

  task automatic t_slave_addr;
    master_mode = 0; stop_mask = 1;
    p_start(); p_addr(); chk("R8 match alone no set", flag_q, 1'b0);
    pairs(8); p_rise(); chk("R8 9th rise after match", flag_q, 1'b1);
    clear_flag(); p_fall();
    pairs(8); p_rise(); chk("R8 next byte also sets", flag_q, 1'b1);
    clear_flag(); p_fall();
    stop_mask = 0;
    p_stop(); chk("R10 unmasked stop", flag_q, 1'b1);
    clear_flag();
    p_start(); pairs(8); p_rise();
    chk("R8 session ended by stop", flag_q, 1'b0);
    p_fall(); p_stop(); clear_flag();
  endtask

  task automatic t_slave_gcall;
    master_mode = 0; stop_mask = 1;
    p_start(); p_gcall();
    pairs(8); p_rise(); chk("R9 9th rise after general call", flag_q, 1'b1);
    clear_flag(); p_fall();
    p_start(); pairs(8); p_rise();
    chk("R9 session ended by repeated start", flag_q, 1'b0);
    p_fall(); p_stop(); stop_mask = 0;
  endtask

  task automatic t_clear;
    stop_mask = 0;
    p_stop(); chk("R10 stop sets", flag_q, 1'b1);
    do_write(1'b0); chk("R11 blind write 0 ignored", flag_q, 1'b1);
    do_read(); do_write(1'b1); chk("R11 write 1 ignored", flag_q, 1'b1);
    gie = 0; @(negedge clk); chk("R12 irq masked", irq, 1'b0);
    gie = 1; @(negedge clk); chk("R12 irq follows flag", irq, 1'b1);
    do_read();
    flag_wr = 1; flag_wdata = 0; stop_det = 1;
    @(negedge clk);
    flag_wr = 0; stop_det = 0;
    chk("R11 set wins over clear", flag_q, 1'b1);
    clear_flag(); chk("R11 read then write 0 clears", flag_q, 1'b0);
    chk("R12 irq low after clear", irq, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_master_wait();
    t_master_nowait();
    t_ack();
    t_arb();
    t_slave_addr();
    t_slave_gcall();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule